// File: doc/BRIEF.md
# Age-Ordered Micro-op Scheduler Queue

This block is a small reservation queue that sits between rename and one execution unit. It holds micro-operations until their source operands can be delivered, then sends one per cycle to the unit. The order of issue is not program order: the oldest entry whose operands are ready and whose unit will be free goes first. Each entry carries a destination tag, an age stamp, up to `NSRC` source tags and a latency class. The latency class tells consumers when the uop's result becomes usable.

Wakeup is predictive. When a uop issues with a fixed-latency class, the queue starts a countdown in every entry that consumes its tag. Each consumer can then be picked exactly the class latency later, so that it meets the result at the unit and does not wait for it to be written back. Uops of the variable-latency class (loads) give no prediction, and their consumers wait for an explicit result broadcast. A per-entry flag limits a uop to even ticks. For such uops the `tick_odd` input masks them out of selection.

Allocation is a valid/ready stream. A uop is written when `alloc_valid` and `alloc_ready` are both high at a clock edge. `alloc_ready` is low exactly when every slot is occupied, and while it is low `alloc_valid` is ignored, so the sender must hold the uop. Issue is a push with no acknowledgement. `iss_valid` is combinational from the stored entries and the inputs `unit_busy` and `tick_odd`. `unit_busy` is the only back-pressure on issue. The granted entry leaves the queue at the end of the cycle in which it issues.

Top module: `uop_sched_queue`

## Requirements
- R1: The queue holds `DEPTH` uops. `alloc_ready` is high while at least one slot is free and low when all `DEPTH` slots hold uops. An `alloc_valid` pulse while `alloc_ready` is low is dropped and that uop never issues.
- R2: While `unit_busy` is high, `iss_valid` stays low whatever the queue holds.
- R3: Among all eligible entries, the one with the oldest age stamp issues. Age comparison is modular: stamp a is older than b when bit `AGE_W-1` of (a - b) is set. This stays correct across wraparound while live stamps span fewer than 2^(AGE_W-1) values.
- R4: When `tick_odd` is high, entries allocated with `alloc_even_only`=1 cannot issue. Entries without the flag are unaffected.
- R5: The latency class codes are 0→`LAT_A`, 1→`LAT_B`, 2→`LAT_C` and 3→variable. When a uop of class 0–2 issues in cycle t, a waiting consumer of its tag becomes eligible in cycle t+L, where L is that latency.
- R6: A uop of class 3 creates no predicted wakeup. Its consumers become eligible in the cycle after `wb_valid` is asserted with `wb_tag` equal to their source tag.
- R7: A uop allocated in the same cycle as a matching `wb_valid`/`wb_tag` broadcast records that source as ready and is eligible in the next cycle.
- R8: A slot freed by issue in cycle t can be allocated again in cycle t+1. When the queue was full in cycle t, `alloc_ready` rises in cycle t+1.
- R9: A uop whose `alloc_src_rdy` bits are all set is eligible in the cycle after its allocation.
- R10: After reset, no slot is occupied: `alloc_ready`=1 and `iss_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | A free slot exists (not full) |
| alloc_tag | input | TAG_W | Destination tag of the new uop |
| alloc_age | input | AGE_W | Age stamp, increasing per allocation |
| alloc_cls | input | 2 | Latency class (0,1,2 fixed; 3 variable) |
| alloc_even_only | input | 1 | Uop may issue only on even ticks |
| alloc_src_tag | input | NSRC*TAG_W | Source tags, source k at bits [k*TAG_W +: TAG_W] |
| alloc_src_rdy | input | NSRC | Source k already available |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Tag of the broadcast result |
| unit_busy | input | 1 | Execution unit will be busy on arrival; blocks issue |
| tick_odd | input | 1 | Current tick is odd |
| iss_valid | output | 1 | A uop issues this cycle |
| iss_tag | output | TAG_W | Tag of the issued uop |
| iss_cls | output | 2 | Latency class of the issued uop |

## Verification
The bench builds the queue with `DEPTH`=10, `AGE_W`=5 and latencies 1, 2 and 4. With a depth that is not a power of two, the full/free search and the picker are tested on a size other than the default. With five stamp bits, a run of stamps 30, 31, 1 exercises the wraparound in the age comparison. With three distinct fixed latencies, one dependent chain shows that each consumer issues exactly its producer's latency after that producer, including the case where a consumer is allocated while its producer issues.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Latency class carried by each uop; it tells consumers when its result is usable.
  typedef enum logic [1:0] {
    CLS_LA  = 2'd0,
    CLS_LB  = 2'd1,
    CLS_LC  = 2'd2,
    CLS_VAR = 2'd3
  } lat_cls_e;
endpackage

// File: rtl/sched_src_track.sv
// One source operand of one slot: tag, ready flag and predicted-wakeup countdown.
module sched_src_track
  import sched_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int LAT_A = 1,
  parameter int LAT_B = 2,
  parameter int LAT_C = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic             ld_rdy,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             iw_valid,
  input  logic [TAG_W-1:0] iw_tag,
  input  lat_cls_e         iw_cls,
  output logic             rdy
);
  localparam int LAT_AB  = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int LAT_MAX = (LAT_AB > LAT_C) ? LAT_AB : LAT_C;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic [TAG_W-1:0] tag_q, cmp_tag;
  logic             rdy_q;
  logic [CNT_W-1:0] cnt_q, lat;
  logic             ext_hit, int_hit;

  always_comb begin
    case (iw_cls)
      CLS_LA:  lat = CNT_W'(LAT_A);
      CLS_LB:  lat = CNT_W'(LAT_B);
      CLS_LC:  lat = CNT_W'(LAT_C);
      default: lat = '0;
    endcase
    cmp_tag = load ? ld_tag : tag_q;
    ext_hit = wb_valid && (wb_tag == cmp_tag);
    int_hit = iw_valid && (iw_tag == cmp_tag) && (iw_cls != CLS_VAR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      tag_q <= ld_tag;
      if (ld_rdy || ext_hit) begin
        rdy_q <= 1'b1;
        cnt_q <= '0;
      end else if (int_hit) begin
        // producer issues in the allocation cycle: start the countdown at once
        rdy_q <= (lat == CNT_W'(1));
        cnt_q <= lat - CNT_W'(1);
      end else begin
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end
    end else if (!rdy_q) begin
      if (ext_hit) begin
        rdy_q <= 1'b1;
        cnt_q <= '0;
      end else if (int_hit) begin
        rdy_q <= (lat == CNT_W'(1));
        cnt_q <= lat - CNT_W'(1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
      end
    end
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/sched_slot.sv
// One queue slot: stored uop fields plus one tracker per source operand.
module sched_slot
  import sched_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int AGE_W = 5,
  parameter int NSRC  = 2,
  parameter int LAT_A = 1,
  parameter int LAT_B = 2,
  parameter int LAT_C = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [TAG_W-1:0]      in_tag,
  input  logic [AGE_W-1:0]      in_age,
  input  logic [1:0]            in_cls,
  input  logic                  in_even,
  input  logic [NSRC*TAG_W-1:0] in_src_tag,
  input  logic [NSRC-1:0]       in_src_rdy,
  input  logic                  clr,
  input  logic                  wb_valid,
  input  logic [TAG_W-1:0]      wb_tag,
  input  logic                  iw_valid,
  input  logic [TAG_W-1:0]      iw_tag,
  input  logic [1:0]            iw_cls,
  output logic                  occupied,
  output logic                  all_rdy,
  output logic [TAG_W-1:0]      tag,
  output logic [AGE_W-1:0]      age,
  output logic [1:0]            cls,
  output logic                  even_only
);
  logic [NSRC-1:0] src_rdy;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    sched_src_track #(
      .TAG_W(TAG_W), .LAT_A(LAT_A), .LAT_B(LAT_B), .LAT_C(LAT_C)
    ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (we),
      .ld_tag   (in_src_tag[s*TAG_W +: TAG_W]),
      .ld_rdy   (in_src_rdy[s]),
      .wb_valid (wb_valid),
      .wb_tag   (wb_tag),
      .iw_valid (iw_valid),
      .iw_tag   (iw_tag),
      .iw_cls   (lat_cls_e'(iw_cls)),
      .rdy      (src_rdy[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occupied  <= 1'b0;
      tag       <= '0;
      age       <= '0;
      cls       <= '0;
      even_only <= 1'b0;
    end else if (we) begin
      occupied  <= 1'b1;
      tag       <= in_tag;
      age       <= in_age;
      cls       <= in_cls;
      even_only <= in_even;
    end else if (clr) begin
      occupied  <= 1'b0;
    end
  end

  assign all_rdy = &src_rdy;
endmodule

// File: rtl/sched_free_find.sv
// Lowest-index free slot, one-hot, and a flag that any slot is free.
module sched_free_find #(
  parameter int N = 8
) (
  input  logic [N-1:0] occupied,
  output logic [N-1:0] pick,
  output logic         any_free
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (!occupied[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign any_free = ~&occupied;
endmodule

// File: rtl/sched_oldest_pick.sv
// One-hot grant to the oldest requesting slot, using modular age comparison.
module sched_oldest_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 5
) (
  input  logic [N-1:0]     req,
  input  logic [AGE_W-1:0] age [N],
  output logic [N-1:0]     gnt
);
  always_comb begin
    logic [AGE_W-1:0] d;
    gnt = '0;
    d   = '0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = req[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && req[j]) begin
          d = age[i] - age[j];
          // i loses to a younger-or-equal comparison; equal stamps fall back to lower index
          if (d == '0) begin
            if (j < i) gnt[i] = 1'b0;
          end else if (!d[AGE_W-1]) begin
            gnt[i] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uop_sched_queue.sv
module uop_sched_queue
  import sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int AGE_W = 5,
  parameter int NSRC  = 2,
  parameter int LAT_A = 1,
  parameter int LAT_B = 2,
  parameter int LAT_C = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_valid,
  output logic                  alloc_ready,
  input  logic [TAG_W-1:0]      alloc_tag,
  input  logic [AGE_W-1:0]      alloc_age,
  input  logic [1:0]            alloc_cls,
  input  logic                  alloc_even_only,
  input  logic [NSRC*TAG_W-1:0] alloc_src_tag,
  input  logic [NSRC-1:0]       alloc_src_rdy,
  input  logic                  wb_valid,
  input  logic [TAG_W-1:0]      wb_tag,
  input  logic                  unit_busy,
  input  logic                  tick_odd,
  output logic                  iss_valid,
  output logic [TAG_W-1:0]      iss_tag,
  output logic [1:0]            iss_cls
);
  logic [DEPTH-1:0] slot_occ, slot_rdy, slot_even, free_pick, req, grant;
  logic [TAG_W-1:0] slot_tag [DEPTH];
  logic [AGE_W-1:0] slot_age [DEPTH];
  logic [1:0]       slot_cls [DEPTH];
  logic             any_free, alloc_fire, iss_even;

  assign alloc_ready = any_free;
  assign alloc_fire  = alloc_valid && any_free;

  sched_free_find #(.N(DEPTH)) u_free (
    .occupied (slot_occ),
    .pick     (free_pick),
    .any_free (any_free)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    sched_slot #(
      .TAG_W(TAG_W), .AGE_W(AGE_W), .NSRC(NSRC),
      .LAT_A(LAT_A), .LAT_B(LAT_B), .LAT_C(LAT_C)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (alloc_fire && free_pick[i]),
      .in_tag     (alloc_tag),
      .in_age     (alloc_age),
      .in_cls     (alloc_cls),
      .in_even    (alloc_even_only),
      .in_src_tag (alloc_src_tag),
      .in_src_rdy (alloc_src_rdy),
      .clr        (grant[i]),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .iw_valid   (iss_valid),
      .iw_tag     (iss_tag),
      .iw_cls     (iss_cls),
      .occupied   (slot_occ[i]),
      .all_rdy    (slot_rdy[i]),
      .tag        (slot_tag[i]),
      .age        (slot_age[i]),
      .cls        (slot_cls[i]),
      .even_only  (slot_even[i])
    );
    assign req[i] = slot_occ[i] && slot_rdy[i] && !(slot_even[i] && tick_odd) && !unit_busy;
  end

  sched_oldest_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_pick (
    .req (req),
    .age (slot_age),
    .gnt (grant)
  );

  always_comb begin
    iss_tag  = '0;
    iss_cls  = '0;
    iss_even = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        iss_tag  = iss_tag | slot_tag[i];
        iss_cls  = iss_cls | slot_cls[i];
        iss_even = iss_even | slot_even[i];
      end
    end
  end

  assign iss_valid = |grant;
endmodule

// File: rtl/sched_queue_checker.sv
module sched_queue_checker #(
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             unit_busy,
  input logic             tick_odd,
  input logic             iss_valid,
  input logic             iss_even,
  input logic [DEPTH-1:0] grant
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  logic [OCC_W-1:0] occ;

  // independent occupancy count from the port-level handshakes
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OCC_W'(alloc_valid && alloc_ready) - OCC_W'(iss_valid);
  end

  p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_W'(DEPTH)) |-> !alloc_ready);
  p_room_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < OCC_W'(DEPTH)) |-> alloc_ready);
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unit_busy |-> !iss_valid);
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_even_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && tick_odd) |-> !iss_even);
  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !iss_valid);
endmodule

bind uop_sched_queue sched_queue_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .unit_busy   (unit_busy),
  .tick_odd    (tick_odd),
  .iss_valid   (iss_valid),
  .iss_even    (iss_even),
  .grant       (grant)
);

// File: tb/uop_sched_queue_bench.sv
module uop_sched_queue_bench;
  localparam int DEPTH = 10;
  localparam int TAG_W = 6;
  localparam int AGE_W = 5;
  localparam int NSRC  = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                  rst_n = 1'b0;
  logic                  alloc_valid = 1'b0, alloc_ready;
  logic [TAG_W-1:0]      alloc_tag = '0;
  logic [AGE_W-1:0]      alloc_age = '0;
  logic [1:0]            alloc_cls = '0;
  logic                  alloc_even_only = 1'b0;
  logic [NSRC*TAG_W-1:0] alloc_src_tag = '0;
  logic [NSRC-1:0]       alloc_src_rdy = '0;
  logic                  wb_valid = 1'b0;
  logic [TAG_W-1:0]      wb_tag = '0;
  logic                  unit_busy = 1'b0, tick_odd = 1'b0;
  logic                  iss_valid;
  logic [TAG_W-1:0]      iss_tag;
  logic [1:0]            iss_cls;

  uop_sched_queue #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W), .NSRC(NSRC),
    .LAT_A(1), .LAT_B(2), .LAT_C(4)
  ) u_uop_sched_queue (.*);

  int cyc = 0, total = 0, fails = 0, agen = 0, n_iss = 0;
  int iss_at [64];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n && iss_valid) begin
      iss_at[iss_tag] = cyc;
      n_iss++;
    end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string what, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic put(int tag, int cls, bit even, int s0, bit r0, int s1, bit r1);
    alloc_valid     = 1'b1;
    alloc_tag       = TAG_W'(tag);
    alloc_age       = AGE_W'(agen);
    alloc_cls       = 2'(cls);
    alloc_even_only = even;
    alloc_src_tag   = {TAG_W'(s1), TAG_W'(s0)};
    alloc_src_rdy   = {r1, r0};
    agen            = (agen + 1) % 32;
    step(1);
    alloc_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R10 alloc_ready after reset", int'(alloc_ready), 1);
    chk("R10 iss_valid after reset", int'(iss_valid), 0);
    step(1);
  endtask

  task automatic t_chain();
    int c0;
    c0 = cyc;
    put(1, 0, 0, 0, 1, 0, 1);
    put(2, 1, 0, 1, 0, 1, 0);
    put(3, 2, 0, 2, 0, 2, 0);
    put(4, 0, 0, 3, 0, 3, 0);
    step(8);
    chk("R9 ready uop issues cycle after alloc", iss_at[1], c0 + 1);
    chk("R5 latency-1 consumer gap", iss_at[2] - iss_at[1], 1);
    chk("R5 latency-2 consumer gap", iss_at[3] - iss_at[2], 2);
    chk("R5 latency-4 consumer gap", iss_at[4] - iss_at[3], 4);
  endtask

  task automatic t_oldest();
    int cb;
    unit_busy = 1'b1;
    agen = 1;  put(10, 0, 0, 0, 1, 0, 1);
    agen = 31; put(11, 0, 0, 0, 1, 0, 1);
    agen = 30; put(12, 0, 0, 0, 1, 0, 1);
    agen = 2;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk("R2 no issue while unit_busy", int'(iss_valid), 0);
      step(1);
    end
    cb = cyc;
    unit_busy = 1'b0;
    step(4);
    chk("R3 oldest stamp 30 first", iss_at[12], cb);
    chk("R3 stamp 31 second", iss_at[11], cb + 1);
    chk("R3 wrapped stamp 1 last", iss_at[10], cb + 2);
  endtask

  task automatic t_even();
    int c, ce;
    tick_odd = 1'b1;
    c = cyc;
    put(20, 0, 1, 0, 1, 0, 1);
    put(21, 0, 0, 0, 1, 0, 1);
    step(3);
    chk("R4 even-only uop held on odd tick", iss_at[20], -1);
    chk("R4 unrestricted uop issues on odd tick", iss_at[21], c + 2);
    ce = cyc;
    tick_odd = 1'b0;
    step(1);
    chk("R4 even-only uop issues on even tick", iss_at[20], ce);
  endtask

  task automatic t_var();
    int w;
    put(30, 3, 0, 0, 1, 0, 1);
    put(31, 0, 0, 30, 0, 30, 0);
    step(6);
    chk("R6 no predicted wakeup from variable class", iss_at[31], -1);
    w = cyc;
    wb_valid = 1'b1; wb_tag = TAG_W'(30);
    step(1);
    wb_valid = 1'b0;
    step(2);
    chk("R6 consumer issues after broadcast", iss_at[31], w + 1);
  endtask

  task automatic t_same();
    int c;
    c = cyc;
    wb_valid = 1'b1; wb_tag = TAG_W'(41);
    put(40, 0, 0, 41, 0, 41, 0);
    wb_valid = 1'b0;
    step(2);
    chk("R7 broadcast captured at allocation", iss_at[40], c + 1);
  endtask

  task automatic t_full();
    int k0, base;
    unit_busy = 1'b1;
    base = n_iss;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1 alloc_ready while room", int'(alloc_ready), 1);
      put(48 + k, 0, 0, 0, 1, 0, 1);
    end
    chk("R1 alloc_ready low when full", int'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_tag = TAG_W'(60); alloc_src_rdy = '1;
    step(1);
    alloc_valid = 1'b0;
    k0 = cyc;
    chk("R8 still full in issue cycle", int'(alloc_ready), 0);
    unit_busy = 1'b0;
    step(1);
    unit_busy = 1'b1;
    chk("R3 oldest of full queue issues", iss_at[48], k0);
    chk("R8 slot free in next cycle", int'(alloc_ready), 1);
    put(59, 0, 0, 0, 1, 0, 1);
    chk("R8 freed slot reused, full again", int'(alloc_ready), 0);
    unit_busy = 1'b0;
    step(14);
    chk("R1 dropped uop never issues", iss_at[60], -1);
    chk("R1 issue count after drain", n_iss - base, DEPTH + 1);
    chk("R1 alloc_ready after drain", int'(alloc_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) iss_at[i] = -1;
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_oldest();
    t_even();
    t_var();
    t_same();
    t_full();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule